// File: doc/BRIEF.md
# Load-Bypassing Store Buffer Scheduler

This block orders memory micro-ops between dispatch and a single cache port. Loads and stores arrive one per cycle on a dispatch interface, each carrying a word address and an identifier. They are held in two separate in-order reservation queues, one for loads and one for stores. A store computes its address and moves into a four-entry store buffer. There it waits for a retire pulse from the commit logic and then drains to the cache. A load computes its address and goes straight to the cache. It may overtake older buffered stores, but only when its address differs from every one of them. No data is ever forwarded from a store to a load.

Each cycle the port arbiter settles on one of three grant kinds. GNT_NONE means no access. GNT_LOAD means the head load uses the port. GNT_STORE means the oldest retired store drains. The transitions are these. An eligible head load always selects GNT_LOAD. Failing that, a retired head store in the buffer selects GNT_STORE. Otherwise the arbiter falls back to GNT_NONE. An op that arrives at an empty queue is evaluated in the same cycle it is dispatched. A queue entry is released at the clock edge that closes its address-generation and issue cycle. A buffered store's entry is released at the edge that closes its cache-access cycle. Every access is assumed to hit.

Top module: `lbsb_sched`

## Requirements
- R1: `disp_ready` is low while the queue of the dispatched kind (`disp_is_store`=1 for the store queue, 0 for the load queue) already holds 4 entries; a dispatch seen with `disp_ready` low is dropped.
- R2: An op dispatched into an empty queue performs address generation in its dispatch cycle; a load that is eligible appears on the cache port in that same cycle.
- R3: Loads reach the cache in program order among loads, and stores reach the cache in program order among stores.
- R4: At most one access is on the cache port per cycle; when an eligible load and a drainable store compete, the load is granted and the store goes in a later cycle.
- R5: A load whose address matches no buffered store is granted ahead of those older buffered stores.
- R6: A load whose address equals that of any buffered store waits, without forwarding, until that store has drained; it is granted no earlier than the cycle after the drain.
- R7: A retire pulse marks the oldest unmarked buffered store, and that store may drain no earlier than the next cycle. A pulse that finds no unmarked buffered store is ignored. No store drains without a pulse.
- R8: At most one store enters the store buffer per cycle, and none enters while the buffer's 4 entries are occupied; such a store stays in the store queue.
- R9: A load is not granted while any store older than it is still in the store queue.
- R10: After reset, the cache port is idle (`cache_valid`=0) and `disp_ready` is high for both kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch of one op this cycle |
| disp_is_store | input | 1 | 1 = store, 0 = load |
| disp_addr | input | AW | Word address of the op |
| disp_id | input | IW | Identifier carried to the cache port |
| disp_ready | output | 1 | Queue of the dispatched kind has space |
| retire_pulse | input | 1 | Commit marks the oldest unmarked buffered store |
| cache_valid | output | 1 | An access is on the cache port this cycle |
| cache_is_store | output | 1 | 1 = store drain, 0 = load |
| cache_addr | output | AW | Address of the access |
| cache_id | output | IW | Identifier of the accessing op |

## Verification
Several properties are checked by assertions on every cycle. A granted load never matches any valid store-buffer address. No store drains unless retire pulses from earlier cycles allow it. A full store buffer never grows. A full load queue deasserts ready. The same-cycle dispatch path, load priority over a drainable store, in-order granting, and the waiting of loads behind stores whose address is not yet computed all depend on cycle timing across sequences. These only show up in the bench's scenarios, where the per-cycle port trace is compared against a behavioural queue model.

// File: rtl/lbsb_pkg.sv
package lbsb_pkg;
    typedef enum logic [1:0] {
        GNT_NONE  = 2'd0,
        GNT_LOAD  = 2'd1,
        GNT_STORE = 2'd2
    } port_gnt_e;
endpackage

// File: rtl/lbsb_rs_fifo.sv
// In-order reservation queue; entry freed at the edge closing its issue cycle.
module lbsb_rs_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign head  = mem[rd_ptr];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/lbsb_store_buf.sv
// Store buffer: address match for loads, in-order retire marking and drain.
module lbsb_store_buf #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int IW    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  logic [AW-1:0]         push_addr,
    input  logic [IW-1:0]         push_id,
    input  logic                  pop,
    input  logic                  mark,
    input  logic [AW-1:0]         query_addr,
    output logic                  hit,
    output logic                  head_rdy,
    output logic [AW-1:0]         head_addr,
    output logic [IW-1:0]         head_id,
    output logic                  full,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [DEPTH-1:0]      vld,
    output logic [DEPTH*AW-1:0]   addr_flat
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] addr_q [DEPTH];
    logic [IW-1:0] id_q   [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] rdy_cnt;
    logic          mark_ok;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // marked entries are always a prefix from the head, so a count suffices (R7)
    assign mark_ok   = mark && (rdy_cnt < count);
    assign head_rdy  = (rdy_cnt != '0);
    assign head_addr = addr_q[rd_ptr];
    assign head_id   = id_q[rd_ptr];
    assign full      = (count == CW'(DEPTH));

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_flat
            assign addr_flat[g*AW +: AW] = addr_q[g];
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (vld[i] && addr_q[i] == query_addr) hit = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count   <= '0;
            rdy_cnt <= '0;
            vld     <= '0;
        end else begin
            if (push) begin
                addr_q[wr_ptr] <= push_addr;
                id_q[wr_ptr]   <= push_id;
                vld[wr_ptr]    <= 1'b1;
                wr_ptr         <= bump(wr_ptr);
            end
            if (pop) begin
                vld[rd_ptr] <= 1'b0;
                rd_ptr      <= bump(rd_ptr);
            end
            count   <= count + CW'(push) - CW'(pop);
            rdy_cnt <= rdy_cnt + CW'(mark_ok) - CW'(pop);
        end
    end
endmodule

// File: rtl/lbsb_sched.sv
module lbsb_sched
    import lbsb_pkg::*;
#(
    parameter int AW        = 16,
    parameter int IW        = 8,
    parameter int LRS_DEPTH = 4,
    parameter int SRS_DEPTH = 4,
    parameter int SB_DEPTH  = 4,
    parameter int CNT_W     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          disp_valid,
    input  logic          disp_is_store,
    input  logic [AW-1:0] disp_addr,
    input  logic [IW-1:0] disp_id,
    output logic          disp_ready,
    input  logic          retire_pulse,
    output logic          cache_valid,
    output logic          cache_is_store,
    output logic [AW-1:0] cache_addr,
    output logic [IW-1:0] cache_id
);
    localparam int LW  = CNT_W + IW + AW;
    localparam int SW  = IW + AW;
    localparam int SBC = $clog2(SB_DEPTH + 1);

    port_gnt_e gnt;

    logic           ld_in, st_in;
    logic           lrs_empty, lrs_full, srs_empty, srs_full;
    logic           lrs_push, lrs_pop, srs_push, srs_pop;
    logic [LW-1:0]  lrs_head, ld_h;
    logic [SW-1:0]  srs_head, st_h;
    logic           ld_h_v, st_h_v, ld_ok, st_agen;
    logic [AW-1:0]  ld_h_addr, st_h_addr;
    logic [IW-1:0]  ld_h_id, st_h_id;
    logic [CNT_W-1:0] ld_h_stb, order_diff;
    logic [CNT_W-1:0] st_disp_cnt, st_agen_cnt;

    logic                   sb_hit, sb_head_rdy, sb_full, sb_pop;
    logic [AW-1:0]          sb_head_addr;
    logic [IW-1:0]          sb_head_id;
    logic [SBC-1:0]         sb_count;
    logic [SB_DEPTH-1:0]    sb_vld;
    logic [SB_DEPTH*AW-1:0] sb_addr_flat;

    // R1: ready follows the queue of the kind being dispatched
    assign disp_ready = disp_is_store ? !srs_full : !lrs_full;
    assign ld_in      = disp_valid && !disp_is_store && disp_ready;
    assign st_in      = disp_valid &&  disp_is_store && disp_ready;

    // R2: an empty queue exposes the incoming op as its head this cycle
    assign ld_h_v    = !lrs_empty || ld_in;
    assign ld_h      = lrs_empty ? {st_disp_cnt, disp_id, disp_addr} : lrs_head;
    assign ld_h_addr = ld_h[AW-1:0];
    assign ld_h_id   = ld_h[AW +: IW];
    assign ld_h_stb  = ld_h[AW+IW +: CNT_W];

    assign st_h_v    = !srs_empty || st_in;
    assign st_h      = srs_empty ? {disp_id, disp_addr} : srs_head;
    assign st_h_addr = st_h[AW-1:0];
    assign st_h_id   = st_h[AW +: IW];

    // R9: every store older than the load must already have its address
    assign order_diff = st_agen_cnt - ld_h_stb;
    // R5/R6: bypass only when no buffered store shares the address
    assign ld_ok      = ld_h_v && !order_diff[CNT_W-1] && !sb_hit;
    // R8: one store address per cycle, held back by a full buffer
    assign st_agen    = st_h_v && !sb_full;

    // R4: arbitration for the single cache port, loads first
    always_comb begin
        if (ld_ok)            gnt = GNT_LOAD;
        else if (sb_head_rdy) gnt = GNT_STORE;
        else                  gnt = GNT_NONE;
    end

    assign lrs_pop  = (gnt == GNT_LOAD) && !lrs_empty;
    assign lrs_push = ld_in && !(lrs_empty && gnt == GNT_LOAD);
    assign srs_pop  = st_agen && !srs_empty;
    assign srs_push = st_in && !(srs_empty && st_agen);
    assign sb_pop   = (gnt == GNT_STORE);

    lbsb_rs_fifo #(.DEPTH(LRS_DEPTH), .W(LW)) u_ldq (
        .clk(clk), .rst_n(rst_n), .push(lrs_push),
        .push_data({st_disp_cnt, disp_id, disp_addr}), .pop(lrs_pop),
        .head(lrs_head), .empty(lrs_empty), .full(lrs_full)
    );

    lbsb_rs_fifo #(.DEPTH(SRS_DEPTH), .W(SW)) u_stq (
        .clk(clk), .rst_n(rst_n), .push(srs_push),
        .push_data({disp_id, disp_addr}), .pop(srs_pop),
        .head(srs_head), .empty(srs_empty), .full(srs_full)
    );

    lbsb_store_buf #(.DEPTH(SB_DEPTH), .AW(AW), .IW(IW)) u_sb (
        .clk(clk), .rst_n(rst_n), .push(st_agen), .push_addr(st_h_addr),
        .push_id(st_h_id), .pop(sb_pop), .mark(retire_pulse),
        .query_addr(ld_h_addr), .hit(sb_hit), .head_rdy(sb_head_rdy),
        .head_addr(sb_head_addr), .head_id(sb_head_id), .full(sb_full),
        .count(sb_count), .vld(sb_vld), .addr_flat(sb_addr_flat)
    );

    // state register: program-order store counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_disp_cnt <= '0;
            st_agen_cnt <= '0;
        end else begin
            st_disp_cnt <= st_disp_cnt + CNT_W'(st_in);
            st_agen_cnt <= st_agen_cnt + CNT_W'(st_agen);
        end
    end

    // output process
    always_comb begin
        cache_valid    = 1'b0;
        cache_is_store = 1'b0;
        cache_addr     = '0;
        cache_id       = '0;
        unique case (gnt)
            GNT_LOAD: begin
                cache_valid = 1'b1;
                cache_addr  = ld_h_addr;
                cache_id    = ld_h_id;
            end
            GNT_STORE: begin
                cache_valid    = 1'b1;
                cache_is_store = 1'b1;
                cache_addr     = sb_head_addr;
                cache_id       = sb_head_id;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lbsb_sched_chk.sv
module lbsb_sched_chk #(
    parameter int AW       = 16,
    parameter int SB_DEPTH = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   disp_valid,
    input logic                   disp_is_store,
    input logic                   disp_ready,
    input logic                   retire_pulse,
    input logic                   cache_valid,
    input logic                   cache_is_store,
    input logic [AW-1:0]          cache_addr,
    input logic                   lrs_full,
    input logic                   sb_full,
    input logic [$clog2(SB_DEPTH+1)-1:0] sb_count,
    input logic [SB_DEPTH-1:0]    sb_vld,
    input logic [SB_DEPTH*AW-1:0] sb_addr_flat
);
    logic        alias_hit;
    logic [15:0] credit;

    always_comb begin
        alias_hit = 1'b0;
        for (int i = 0; i < SB_DEPTH; i++)
            if (sb_vld[i] && sb_addr_flat[i*AW +: AW] == cache_addr) alias_hit = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) credit <= '0;
        else        credit <= credit + 16'(retire_pulse)
                              - 16'(cache_valid && cache_is_store);
    end

    p_full_blocks_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_is_store && lrs_full) |-> !disp_ready);

    p_load_no_alias_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_valid && !cache_is_store) |-> !alias_hit);

    p_store_after_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_valid && cache_is_store) |-> (credit != 16'd0));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sb_full |=> (sb_count <= $past(sb_count)));
endmodule

bind lbsb_sched lbsb_sched_chk #(.AW(AW), .SB_DEPTH(SB_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid),
    .disp_is_store(disp_is_store), .disp_ready(disp_ready),
    .retire_pulse(retire_pulse), .cache_valid(cache_valid),
    .cache_is_store(cache_is_store), .cache_addr(cache_addr),
    .lrs_full(lrs_full), .sb_full(sb_full), .sb_count(sb_count),
    .sb_vld(sb_vld), .sb_addr_flat(sb_addr_flat)
);

// File: tb/tb_lbsb_sched.sv
`timescale 1ns/1ps
module tb_lbsb_sched;
    localparam int AW = 16;
    localparam int IW = 8;
    localparam int QD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          disp_valid = 1'b0, disp_is_store = 1'b0, retire_pulse = 1'b0;
    logic [AW-1:0] disp_addr = '0;
    logic [IW-1:0] disp_id = '0;
    logic          disp_ready, cache_valid, cache_is_store;
    logic [AW-1:0] cache_addr;
    logic [IW-1:0] cache_id;

    int n_cmp = 0, n_bad = 0, next_id = 0;

    // behavioural reference state
    int lq_id[$], lq_addr[$], lq_stb[$];
    int sq_id[$], sq_addr[$];
    int bq_id[$], bq_addr[$];
    int bq_rdy = 0, st_disp = 0, st_agen = 0;

    always #2 clk = ~clk;

    lbsb_sched #(.AW(AW), .IW(IW)) dut (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid),
        .disp_is_store(disp_is_store), .disp_addr(disp_addr), .disp_id(disp_id),
        .disp_ready(disp_ready), .retire_pulse(retire_pulse),
        .cache_valid(cache_valid), .cache_is_store(cache_is_store),
        .cache_addr(cache_addr), .cache_id(cache_id)
    );

    function automatic bit buf_match(int a);
        foreach (bq_addr[i]) if (bq_addr[i] == a) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step(bit dv, bit ds, int da, bit rp, string req);
        bit rdy, acc, ld_in, st_in, hv, lok, shv, sag, drn, ev, es, lq_e0, sq_e0;
        int hid, ha, hstb, shid, sha, ea, eid;
        @(negedge clk);
        disp_valid = dv; disp_is_store = ds; disp_addr = AW'(da);
        disp_id = IW'(next_id); retire_pulse = rp;
        #1;
        rdy   = ds ? (sq_id.size() < QD) : (lq_id.size() < QD);
        acc   = dv && rdy;
        ld_in = acc && !ds;
        st_in = acc && ds;
        lq_e0 = (lq_id.size() == 0);
        sq_e0 = (sq_id.size() == 0);
        hv = !lq_e0 || ld_in;
        if (!lq_e0) begin hid = lq_id[0]; ha = lq_addr[0]; hstb = lq_stb[0]; end
        else begin hid = next_id % 256; ha = da; hstb = st_disp; end
        lok = hv && (st_agen >= hstb) && !buf_match(ha);
        shv = !sq_e0 || st_in;
        if (!sq_e0) begin shid = sq_id[0]; sha = sq_addr[0]; end
        else begin shid = next_id % 256; sha = da; end
        sag = shv && (bq_id.size() < QD);
        drn = (bq_rdy > 0);
        ev = lok || drn; es = !lok && drn;
        ea = lok ? ha : (drn ? bq_addr[0] : 0);
        eid = lok ? hid : (drn ? bq_id[0] : 0);
        n_cmp++;
        if (disp_ready !== rdy || cache_valid !== ev ||
            (ev && (cache_is_store !== es || int'(cache_addr) != ea || int'(cache_id) != eid))) begin
            n_bad++;
            $display("FAIL %s t=%0t: got rdy=%0b v=%0b st=%0b a=%0h id=%0d exp rdy=%0b v=%0b st=%0b a=%0h id=%0d",
                     req, $time, disp_ready, cache_valid, cache_is_store, cache_addr, cache_id,
                     rdy, ev, es, ea, eid);
        end
        // advance the reference
        if (lok && !lq_e0) begin void'(lq_id.pop_front()); void'(lq_addr.pop_front()); void'(lq_stb.pop_front()); end
        if (ld_in && !(lq_e0 && lok)) begin lq_id.push_back(next_id % 256); lq_addr.push_back(da); lq_stb.push_back(st_disp); end
        if (rp && bq_rdy < bq_id.size()) bq_rdy++;
        if (es) begin void'(bq_id.pop_front()); void'(bq_addr.pop_front()); bq_rdy--; end
        if (sag) begin
            if (!sq_e0) begin void'(sq_id.pop_front()); void'(sq_addr.pop_front()); end
            bq_id.push_back(shid); bq_addr.push_back(sha);
        end
        if (st_in && !(sq_e0 && sag)) begin sq_id.push_back(next_id % 256); sq_addr.push_back(da); end
        if (st_in) st_disp++;
        if (sag) st_agen++;
        if (dv) next_id++;
    endtask

    task automatic idle(int n, bit rp, string req);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, rp, req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R10: idle port and ready after reset, for both kinds
        idle(2, 1'b0, "R10");
        step(1'b0, 1'b1, 0, 1'b0, "R10");
        // R2: load into empty queue reaches the cache in its dispatch cycle
        step(1'b1, 1'b0, 'h10, 1'b0, "R2");
        idle(1, 1'b0, "R2");
        // R5: store buffered, non-aliasing load overtakes it
        step(1'b1, 1'b1, 'h20, 1'b0, "R5");
        step(1'b1, 1'b0, 'h30, 1'b0, "R5");
        step(1'b0, 1'b0, 0, 1'b1, "R7");
        idle(2, 1'b0, "R7");
        // R6: aliasing load waits until the store has drained
        step(1'b1, 1'b1, 'h40, 1'b0, "R6");
        step(1'b1, 1'b0, 'h40, 1'b0, "R6");
        idle(2, 1'b0, "R6");
        step(1'b0, 1'b0, 0, 1'b1, "R6");
        idle(3, 1'b0, "R6");
        // R1: aliasing store holds loads back until the load queue fills
        step(1'b1, 1'b1, 'h50, 1'b0, "R1");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 'h50, 1'b0, "R1");
        step(1'b0, 1'b0, 0, 1'b1, "R1");
        idle(6, 1'b0, "R3");
        // R4: load and drainable store compete, load first
        step(1'b1, 1'b1, 'h60, 1'b0, "R4");
        step(1'b0, 1'b0, 0, 1'b1, "R4");
        step(1'b1, 1'b0, 'h64, 1'b0, "R4");
        idle(2, 1'b0, "R4");
        // R7: pulse with nothing buffered is ignored; store then needs its own pulse
        step(1'b0, 1'b0, 0, 1'b1, "R7");
        step(1'b1, 1'b1, 'h70, 1'b0, "R7");
        idle(3, 1'b0, "R7");
        step(1'b0, 1'b0, 0, 1'b1, "R7");
        idle(2, 1'b0, "R7");
        // R8/R9: buffer fills, fifth store stays queued, younger load waits for it
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 'h80 + i, 1'b0, "R8");
        step(1'b1, 1'b0, 'h90, 1'b0, "R9");
        idle(2, 1'b0, "R9");
        step(1'b0, 1'b0, 0, 1'b1, "R9");
        idle(3, 1'b0, "R9");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 0, 1'b1, "R8");
        idle(4, 1'b0, "R8");
        // R3: mixed stream, in-order loads behind an aliasing load
        step(1'b1, 1'b1, 'h100, 1'b0, "R3");
        step(1'b1, 1'b0, 'h104, 1'b0, "R3");
        step(1'b1, 1'b1, 'h108, 1'b0, "R3");
        step(1'b1, 1'b0, 'h100, 1'b0, "R3");
        step(1'b1, 1'b0, 'h10C, 1'b1, "R3");
        step(1'b1, 1'b1, 'h104, 1'b1, "R3");
        step(1'b1, 1'b0, 'h108, 1'b0, "R3");
        idle(3, 1'b0, "R3");
        idle(4, 1'b1, "R3");
        idle(3, 1'b0, "R3");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule